// File: doc/BRIEF.md
# Interrupt Flag and Error Capture Registers

This block gathers the event pulses that a serial bus protocol engine raises and turns them into one interrupt line. Each event sets a sticky flag in an 8-bit flag register, if the matching bit of an enable register is set. Software reads the flag register to learn which events happened. That read also clears every sticky flag. The receive flag is different: it is a live copy of a receive-pending level and is not sticky.

Two capture registers record the details of an event:

- **Arbitration-loss capture** holds the bit position at which arbitration was lost.
- **Bus-error capture** holds the error kind, the direction and the frame segment.

Each capture register takes the first event after it is armed and then ignores later events of its kind until software reads it. While it is disarmed, later events of that kind raise no flag either. The register port is plain: an address, a write strobe with data, and a read strobe. Read data is combinational from the address. The side effects of a read (clearing flags, rearming a capture) take effect at the clock edge that ends the read cycle. There is no streaming data path and no back-pressure.

Top module: `can_irq_capture`

## Requirements
- R1: After reset, the following are all zero: the flag register (address 0), the enable register (address 1), both capture registers (addresses 2 and 3) and `irq_o`. Both captures start armed.
- R2: Flag bit positions are: 1 for `ev_tx_done_i`, 2 for `ev_warn_i`, 5 for `ev_passive_i`, 6 for arbitration loss and 7 for bus error. A pulse sets its flag from the next cycle, but only when the enable bit at the same position is 1. Bits 3 and 4 of the flag register always read 0.
- R3: A read of address 0 returns the current flags. It then clears flag bits 1, 2, 5, 6 and 7.
- R4: Flag bit 0 equals `rx_pending_i` AND enable bit 0, as a level. A read of address 0 does not clear it.
- R5: An enabled event in the same cycle as a read of address 0 leaves its flag set after that read.
- R6: `irq_o` is 1 exactly when any flag bit is 1.
- R7: The bus-error capture at address 3 reads as kind in bits 7:6 (0 bit, 1 form, 2 stuff, 3 other), direction in bit 5 (0 transmit, 1 receive) and segment code in bits 4:0.
  - The segment codes used include 8 CRC sequence, 25 ACK slot and 26 end of frame.
  - The first bus error while armed is stored and disarms the capture, whatever the enable bit says.
  - Later bus errors neither overwrite the capture nor set flag 7 until address 3 is read.
- R8: The arbitration-loss capture at address 2 reads as the 5-bit lost position in bits 4:0, with zeros above. It arms, disarms and gates flag 6 in the same way as R7, and is rearmed by a read of address 2.
- R9: The enable register is written at address 1 only while `init_mode_i` is 1.
  - A write stores data bits 0, 1, 2, 5, 6 and 7.
  - Bit 4 keeps its value on such a write.
  - Bit 3 stays 0.
- R10: A write to address 4 while `init_mode_i` is 1 sets the prescaler-doubling control from data bit 0. The control reads back as enable bit 4 and as bit 0 of address 4, and drives `prescale_x2_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_mode_i | input | 1 | Controller is in configuration (reset) mode |
| rx_pending_i | input | 1 | Received frames are waiting (level) |
| ev_tx_done_i | input | 1 | Transmission finished (pulse) |
| ev_warn_i | input | 1 | Error warning state changed (pulse) |
| ev_passive_i | input | 1 | Error passive state changed (pulse) |
| ev_arb_lost_i | input | 1 | Arbitration lost (pulse) |
| ev_arb_pos_i | input | 5 | Bit position of arbitration loss |
| ev_bus_err_i | input | 1 | Bus error detected (pulse) |
| ev_err_kind_i | input | 2 | Bus error kind |
| ev_err_dir_i | input | 1 | Bus error direction |
| ev_err_seg_i | input | 5 | Frame segment code of the bus error |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_i | input | 1 | Read strobe (triggers side effects) |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| prescale_x2_o | output | 1 | Prescaler-doubling control |

## Verification
The collision that matters is an event pulse in the same cycle as the clearing read of the flag register. The bench drives a warning pulse in the very cycle in which it reads address 0. The read must return the older flags. A second read must still show the warning flag.

A second same-cycle case puts further bus errors and arbitration losses inside the disarmed window. Each capture register must keep its first value and raise no new flag until it is read. Only after that read must a fresh event be captured.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int POS_W  = 5;
  localparam int SEG_W  = 5;
  localparam int KIND_W = 2;
  localparam int ECAP_W = KIND_W + 1 + SEG_W;

  localparam int FB_RX    = 0;
  localparam int FB_TX    = 1;
  localparam int FB_WARN  = 2;
  localparam int FB_PRESC = 4;
  localparam int FB_PASS  = 5;
  localparam int FB_ARB   = 6;
  localparam int FB_BERR  = 7;

  localparam logic [DATA_W-1:0] EN_WR_MASK   = 8'hE7;
  localparam logic [DATA_W-1:0] STICKY_MASK  = 8'hE6;

  typedef enum logic [ADDR_W-1:0] {
    RA_FLAGS  = 3'd0,
    RA_ENABLE = 3'd1,
    RA_ARBCAP = 3'd2,
    RA_ERRCAP = 3'd3,
    RA_TIMING = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/capture_slot.sv
module capture_slot #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_i,
  input  logic [W-1:0] value_i,
  input  logic         rearm_i,
  output logic         take_o,
  output logic [W-1:0] value_o
);
  logic         armed_q;
  logic [W-1:0] val_q;

  assign take_o  = hit_i & armed_q;
  assign value_o = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      val_q   <= '0;
    end else begin
      if (take_o) val_q <= value_i;
      if (rearm_i)     armed_q <= 1'b1;
      else if (take_o) armed_q <= 1'b0;
    end
  end

  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> $stable(val_q));

  // R8
  capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (val_q == $past(value_i)));
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import can_irq_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  input  logic         rx_level_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] sticky_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (STICKY_MASK[b]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (!rst_n) sticky_q[b] <= 1'b0;
        else        sticky_q[b] <= (sticky_q[b] & ~clr_i) | (set_i[b] & en_i[b]);
      end

      // R2
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[b] && en_i[b]) |=> flags_o[b]);

      // R3
      flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(set_i[b] && en_i[b])) |=> !flags_o[b]);
    end else begin : g_const
      always_ff @(posedge clk) sticky_q[b] <= 1'b0;
    end
  end

  always_comb begin
    flags_o        = sticky_q;
    flags_o[FB_RX] = rx_level_i & en_i[FB_RX];
  end
endmodule

// File: rtl/can_irq_capture.sv
module can_irq_capture
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_mode_i,
  input  logic              rx_pending_i,
  input  logic              ev_tx_done_i,
  input  logic              ev_warn_i,
  input  logic              ev_passive_i,
  input  logic              ev_arb_lost_i,
  input  logic [POS_W-1:0]  ev_arb_pos_i,
  input  logic              ev_bus_err_i,
  input  logic [KIND_W-1:0] ev_err_kind_i,
  input  logic              ev_err_dir_i,
  input  logic [SEG_W-1:0]  ev_err_seg_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              prescale_x2_o
);
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] flags;
  logic [DATA_W-1:0] set_vec;
  logic              arb_take, berr_take;
  logic [POS_W-1:0]  arb_cap;
  logic [ECAP_W-1:0] err_cap;
  logic              rd_flags, rd_arb, rd_err, cfg_wr_en, cfg_wr_tim;

  assign rd_flags   = reg_rd_i && (reg_addr_i == RA_FLAGS);
  assign rd_arb     = reg_rd_i && (reg_addr_i == RA_ARBCAP);
  assign rd_err     = reg_rd_i && (reg_addr_i == RA_ERRCAP);
  assign cfg_wr_en  = reg_wr_i && init_mode_i && (reg_addr_i == RA_ENABLE);
  assign cfg_wr_tim = reg_wr_i && init_mode_i && (reg_addr_i == RA_TIMING);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (cfg_wr_en) begin
      en_q <= (reg_wdata_i & EN_WR_MASK) | (en_q & ~EN_WR_MASK);
    end else if (cfg_wr_tim) begin
      en_q[FB_PRESC] <= reg_wdata_i[0];
    end
  end

  capture_slot #(.W(POS_W)) u_arb_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (ev_arb_lost_i),
    .value_i (ev_arb_pos_i),
    .rearm_i (rd_arb),
    .take_o  (arb_take),
    .value_o (arb_cap)
  );

  capture_slot #(.W(ECAP_W)) u_err_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (ev_bus_err_i),
    .value_i ({ev_err_kind_i, ev_err_dir_i, ev_err_seg_i}),
    .rearm_i (rd_err),
    .take_o  (berr_take),
    .value_o (err_cap)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FB_TX]   = ev_tx_done_i;
    set_vec[FB_WARN] = ev_warn_i;
    set_vec[FB_PASS] = ev_passive_i;
    set_vec[FB_ARB]  = arb_take;
    set_vec[FB_BERR] = berr_take;
  end

  irq_flags #(.W(DATA_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_vec),
    .en_i       (en_q),
    .clr_i      (rd_flags),
    .rx_level_i (rx_pending_i),
    .flags_o    (flags)
  );

  always_comb begin
    unique case (reg_addr_i)
      RA_FLAGS:  reg_rdata_o = flags;
      RA_ENABLE: reg_rdata_o = en_q;
      RA_ARBCAP: reg_rdata_o = DATA_W'(arb_cap);
      RA_ERRCAP: reg_rdata_o = DATA_W'(err_cap);
      RA_TIMING: reg_rdata_o = DATA_W'(en_q[FB_PRESC]);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o         = |flags;
  assign prescale_x2_o = en_q[FB_PRESC];

  // R9
  en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !init_mode_i) |=> $stable(en_q));

  // R9
  presc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == RA_ENABLE) |=> $stable(en_q[FB_PRESC]));

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && ev_warn_i && en_q[FB_WARN]) |=> irq_o);

  // R7
  berr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !berr_take) |=> !flags[FB_BERR]);
endmodule

// File: tb/can_irq_capture_bench.sv
module can_irq_capture_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_mode = 1'b0, rx_pend = 1'b0;
  logic       ev_tx = 1'b0, ev_warn = 1'b0, ev_pass = 1'b0, ev_arb = 1'b0, ev_berr = 1'b0;
  logic [4:0] arb_pos = '0, err_seg = '0;
  logic [1:0] err_kind = '0;
  logic       err_dir = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, presc;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         finished = 0;

  always #4 clk = ~clk;

  can_irq_capture u_can_irq_capture (
    .clk(clk), .rst_n(rst_n), .init_mode_i(init_mode), .rx_pending_i(rx_pend),
    .ev_tx_done_i(ev_tx), .ev_warn_i(ev_warn), .ev_passive_i(ev_pass),
    .ev_arb_lost_i(ev_arb), .ev_arb_pos_i(arb_pos), .ev_bus_err_i(ev_berr),
    .ev_err_kind_i(err_kind), .ev_err_dir_i(err_dir), .ev_err_seg_i(err_seg),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .irq_o(irq), .prescale_x2_o(presc)
  );

  // monitor: compares every read cycle against the scoreboard
  initial forever begin
    @(negedge clk); #2;
    if (rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_err(input logic [1:0] k, input logic d, input logic [4:0] s);
    @(negedge clk);
    ev_berr = 1'b1; err_kind = k; err_dir = d; err_seg = s;
    @(negedge clk);
    ev_berr = 1'b0;
  endtask

  task automatic arb_lost(input logic [4:0] p);
    @(negedge clk);
    ev_arb = 1'b1; arb_pos = p;
    @(negedge clk);
    ev_arb = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 irq after reset", irq, 1'b0);
    rd_reg(3'd0, 8'h00, "R1 flags");
    rd_reg(3'd1, 8'h00, "R1 enable");
    rd_reg(3'd2, 8'h00, "R1 arb capture");
    rd_reg(3'd3, 8'h00, "R1 err capture");

    // disabled event raises nothing
    @(negedge clk); ev_tx = 1'b1; @(negedge clk); ev_tx = 1'b0;
    rd_reg(3'd0, 8'h00, "R2 disabled tx");

    // enable write outside init mode ignored
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, 8'h00, "R9 locked outside init");

    init_mode = 1'b1;
    wr_reg(3'd4, 8'h01);
    rd_reg(3'd1, 8'h10, "R10 doubling bit in enable");
    rd_reg(3'd4, 8'h01, "R10 doubling readback");
    #2 chk("R10 prescale output", presc, 1'b1);
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, 8'hF7, "R9 enable write");
    wr_reg(3'd1, 8'h00);
    rd_reg(3'd1, 8'h10, "R9 bit4 kept");
    wr_reg(3'd1, 8'hE7);
    init_mode = 1'b0;

    // transmit flag, read clears
    @(negedge clk); ev_tx = 1'b1; @(negedge clk); ev_tx = 1'b0;
    #2 chk("R6 irq on flag", irq, 1'b1);
    rd_reg(3'd0, 8'h02, "R2 tx flag");
    rd_reg(3'd0, 8'h00, "R3 cleared");
    #2 chk("R6 irq cleared", irq, 1'b0);

    @(negedge clk); ev_warn = 1'b1; ev_pass = 1'b1;
    @(negedge clk); ev_warn = 1'b0; ev_pass = 1'b0;
    rd_reg(3'd0, 8'h24, "R2 warn and passive");
    rd_reg(3'd0, 8'h00, "R3 cleared again");

    // receive level
    @(negedge clk); rx_pend = 1'b1;
    rd_reg(3'd0, 8'h01, "R4 rx level");
    rd_reg(3'd0, 8'h01, "R4 rx survives read");
    #2 chk("R6 irq on rx", irq, 1'b1);
    @(negedge clk); rx_pend = 1'b0;
    rd_reg(3'd0, 8'h00, "R4 rx dropped");

    // event in the same cycle as the clearing read
    @(negedge clk); ev_tx = 1'b1; @(negedge clk); ev_tx = 1'b0;
    @(negedge clk);
    ev_warn = 1'b1; addr = 3'd0; rd = 1'b1;
    exp_q.push_back(8'h02); tag_q.push_back("R5 read during event");
    @(negedge clk); ev_warn = 1'b0; rd = 1'b0;
    rd_reg(3'd0, 8'h04, "R5 event wins");

    // bus error capture
    bus_err(2'd2, 1'b1, 5'd8);
    rd_reg(3'd0, 8'h80, "R7 bus error flag");
    bus_err(2'd0, 1'b0, 5'd25);
    rd_reg(3'd0, 8'h00, "R7 disarmed no flag");
    rd_reg(3'd3, 8'hA8, "R7 first capture kept");
    bus_err(2'd3, 1'b0, 5'd26);
    rd_reg(3'd0, 8'h80, "R7 rearmed flag");
    rd_reg(3'd3, 8'hDA, "R7 new capture");

    // arbitration loss capture
    arb_lost(5'd17);
    rd_reg(3'd0, 8'h40, "R8 arb flag");
    arb_lost(5'd3);
    rd_reg(3'd0, 8'h00, "R8 disarmed no flag");
    rd_reg(3'd2, 8'h11, "R8 first capture kept");
    arb_lost(5'd30);
    rd_reg(3'd0, 8'h40, "R8 rearmed flag");
    rd_reg(3'd2, 8'h1E, "R8 new capture");

    // capture without enable
    init_mode = 1'b1;
    wr_reg(3'd1, 8'h00);
    init_mode = 1'b0;
    arb_lost(5'd5);
    rd_reg(3'd0, 8'h00, "R8 no flag when disabled");
    rd_reg(3'd2, 8'h05, "R8 captured while disabled");
    #2 chk("R6 irq idle", irq, 1'b0);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule